// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32.768 kHz time-base enable into the timing events used by a real-time clock. A 15-stage binary prescaler advances by one on every cycle in which the time-base enable is high. A 4-bit rate code picks one stage of that chain. That stage drives a square-wave output and a one-cycle periodic-event pulse. The top stage of the chain gives a 1 Hz tick for the timekeeping core.

Software sets the rate code and a 2-bit divider-select code in the control register. The divider-select code must hold 01 (the 32.768 kHz base) for the chain to run. Any other value holds the chain cleared. Two enable bits from the second control register gate the square wave and the periodic pulse separately. Interrupt flag storage lies outside this block. The consumer latches the periodic pulse.

Top module: `rid_periodic_divider`

## Requirements
- R1: While reset is low, and for the cycles of the synchronous reset release, all three outputs are 0 and the prescaler count is 0.
- R2: The rate code maps to a square-wave period, counted in base ticks: code 1 gives 128, code 2 gives 256, and codes 3 to 15 give 2^(code-1). Code 6 therefore gives 32 ticks, which is 1.024 kHz and a 976.562 µs periodic interval.
- R3: `sqw_o` equals 1 exactly when `sqw_en_i` is 1, the rate code is nonzero, `div_sel_i` is 01, and (count mod period) >= period/2. It follows a change of rate or enable in the same cycle.
- R4: `pi_pulse_o` is 1 for exactly one cycle, in the cycle after a counting edge that brings (count mod period) to period/2. It fires only if `pie_en_i` was 1 at that edge.
- R5: Rate code 0000 keeps `sqw_o` and `pi_pulse_o` at 0.
- R6: `sec_tick_o` is 1 for one cycle after the counting edge that brings the count to 16384. That is 16384 ticks after the chain restarts and then every 32768 ticks. The rate code and the enables do not affect it.
- R7: Whenever `div_sel_i` is not 01, the count is cleared to 0 at the next edge. In that case `sqw_o` is 0, and neither pulse occurs in the following cycle.
- R8: A cycle with `tb_en_i` low leaves the count unchanged, and no pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tb_en_i | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| div_sel_i | input | 2 | Divider-select code; 01 runs the chain |
| rate_i | input | 4 | Rate code choosing the prescaler stage |
| sqw_en_i | input | 1 | Square-wave enable |
| pie_en_i | input | 1 | Periodic-event enable |
| sqw_o | output | 1 | Square-wave output |
| pi_pulse_o | output | 1 | One-cycle periodic-event pulse |
| sec_tick_o | output | 1 | One-cycle 1 Hz tick |

## Verification
`sqw_o` is combinational on the registered count. It is due in the same cycle as an input change and one edge after a counting edge. `pi_pulse_o` and `sec_tick_o` are registered, so each is due in the cycle right after the counting edge that causes it. The bench drives inputs on the falling edge and advances its own tick-count model at the rising edge. It then compares all three outputs at the next falling edge, where both kinds of result have settled. Window counts of pulses at rates 1, 2 and 6, and of 1 Hz ticks over 49152 ticks, confirm the periods.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    DIV_STOP0 = 2'b00,
    DIV_RUN   = 2'b01,
    DIV_STOP2 = 2'b10,
    DIV_STOP3 = 2'b11
  } div_sel_e;
endpackage

// File: rtl/rid_reset_sync.sv
module rid_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rid_prescaler.sv
module rid_prescaler #(
  parameter int CHAIN_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  output logic [CHAIN_W-1:0] cnt_o
);
  logic [CHAIN_W-1:0] cnt_q;
  logic [CHAIN_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rid_rate_decode.sv
module rid_rate_decode #(
  parameter int RATE_W   = 4,
  parameter int IDX_W    = 4,
  parameter int SLOW1_IDX = 6,
  parameter int SLOW2_IDX = 7
) (
  input  logic [RATE_W-1:0] rate,
  output logic [IDX_W-1:0]  idx,
  output logic              valid
);
  localparam logic [RATE_W-1:0] CODE_SLOW1 = RATE_W'(1);
  localparam logic [RATE_W-1:0] CODE_SLOW2 = RATE_W'(2);
  localparam logic [RATE_W-1:0] CODE_OFF   = '0;

  logic [RATE_W-1:0] shifted;

  always_comb begin
    shifted = rate - RATE_W'(2);
    valid   = (rate != CODE_OFF);
    if (rate == CODE_SLOW1)      idx = IDX_W'(SLOW1_IDX);
    else if (rate == CODE_SLOW2) idx = IDX_W'(SLOW2_IDX);
    else if (!valid)             idx = '0;
    else                         idx = IDX_W'(shifted);
  end
endmodule

// File: rtl/rid_tap_probe.sv
module rid_tap_probe #(
  parameter int CHAIN_W = 15,
  parameter int IDX_W   = 4
) (
  input  logic [CHAIN_W-1:0] cnt,
  input  logic [IDX_W-1:0]   idx,
  output logic               level,
  output logic               rise_on_tick
);
  logic low_ones;

  always_comb begin
    level    = 1'b0;
    low_ones = 1'b1;
    for (int i = 0; i < CHAIN_W; i++) begin
      if (IDX_W'(i) == idx) level = cnt[i];
      if (IDX_W'(i) < idx)  low_ones = low_ones & cnt[i];
    end
    rise_on_tick = low_ones & ~level;
  end
endmodule

// File: rtl/rid_pulse_gen.sv
module rid_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rid_periodic_divider.sv
module rid_periodic_divider #(
  parameter int CHAIN_W = 15,
  parameter int RATE_W  = 4,
  parameter int DIV_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              sqw_en_i,
  input  logic              pie_en_i,
  output logic              sqw_o,
  output logic              pi_pulse_o,
  output logic              sec_tick_o
);
  import rid_pkg::*;

  localparam int IDX_W = $clog2(CHAIN_W);
  localparam logic [IDX_W-1:0] SEC_IDX = IDX_W'(CHAIN_W - 1);

  logic               rst_sync_n;
  logic               run;
  logic [CHAIN_W-1:0] cnt;
  logic [IDX_W-1:0]   per_idx;
  logic               per_valid;
  logic               per_level;
  logic               per_rise;
  logic               sec_level;
  logic               sec_rise;
  logic               per_fire;
  logic               sec_fire;

  assign run = (div_sel_i == DIV_W'(DIV_RUN));

  rid_reset_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rid_prescaler #(.CHAIN_W(CHAIN_W)) i_chain (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tb_en_i),
    .cnt_o (cnt)
  );

  rid_rate_decode #(.RATE_W(RATE_W), .IDX_W(IDX_W)) i_dec (
    .rate  (rate_i),
    .idx   (per_idx),
    .valid (per_valid)
  );

  rid_tap_probe #(.CHAIN_W(CHAIN_W), .IDX_W(IDX_W)) i_per_tap (
    .cnt          (cnt),
    .idx          (per_idx),
    .level        (per_level),
    .rise_on_tick (per_rise)
  );

  rid_tap_probe #(.CHAIN_W(CHAIN_W), .IDX_W(IDX_W)) i_sec_tap (
    .cnt          (cnt),
    .idx          (SEC_IDX),
    .level        (sec_level),
    .rise_on_tick (sec_rise)
  );

  always_comb begin
    per_fire = run & tb_en_i & per_valid & pie_en_i & per_rise;
    sec_fire = run & tb_en_i & sec_rise;
    sqw_o    = run & sqw_en_i & per_valid & per_level;
  end

  rid_pulse_gen i_per_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (per_fire),
    .pulse_o (pi_pulse_o)
  );

  rid_pulse_gen i_sec_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (sec_fire),
    .pulse_o (sec_tick_o)
  );

  logic unused_sec_level;
  assign unused_sec_level = sec_level;
endmodule

// File: rtl/rid_periodic_divider_chk.sv
module rid_periodic_divider_chk #(
  parameter int RATE_W = 4,
  parameter int DIV_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tb_en_i,
  input logic [DIV_W-1:0]  div_sel_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              sqw_en_i,
  input logic              pie_en_i,
  input logic              sqw_o,
  input logic              pi_pulse_o,
  input logic              sec_tick_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !sqw_o && !pi_pulse_o && !sec_tick_o); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pi_pulse_o |=> !pi_pulse_o); // R4
  AST_PULSE_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rst_n) pi_pulse_o |-> $past(pie_en_i)); // R4
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n) !sqw_en_i |-> !sqw_o); // R3
  AST_RATE_OFF_SQW: assert property (@(posedge clk) disable iff (!rst_n) (rate_i == '0) |-> !sqw_o); // R5
  AST_RATE_OFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (rate_i == '0) |=> !pi_pulse_o); // R5
  AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sec_tick_o |=> !sec_tick_o); // R6
  AST_HALT_SQW: assert property (@(posedge clk) disable iff (!rst_n) (div_sel_i != DIV_W'(1)) |-> !sqw_o); // R7
  AST_HALT_PULSES: assert property (@(posedge clk) disable iff (!rst_n) (div_sel_i != DIV_W'(1)) |=> !pi_pulse_o && !sec_tick_o); // R7
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !tb_en_i |=> !pi_pulse_o && !sec_tick_o); // R8
endmodule

bind rid_periodic_divider rid_periodic_divider_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tb_en_i    (tb_en_i),
  .div_sel_i  (div_sel_i),
  .rate_i     (rate_i),
  .sqw_en_i   (sqw_en_i),
  .pie_en_i   (pie_en_i),
  .sqw_o      (sqw_o),
  .pi_pulse_o (pi_pulse_o),
  .sec_tick_o (sec_tick_o)
);

// File: tb/test_rid_periodic_divider.sv
`timescale 1ns/1ps
module test_rid_periodic_divider;
  logic       clk;
  logic       rst_n;
  logic       tb_en;
  logic [1:0] div_sel;
  logic [3:0] rate;
  logic       sqw_en;
  logic       pie_en;
  logic       sqw;
  logic       pulse;
  logic       sec;

  int checks;
  int fails;
  int unsigned mcnt;
  logic pexp;
  logic sexp;
  int unsigned seed;

  rid_periodic_divider i_rid_periodic_divider (
    .clk(clk), .rst_n(rst_n), .tb_en_i(tb_en), .div_sel_i(div_sel),
    .rate_i(rate), .sqw_en_i(sqw_en), .pie_en_i(pie_en),
    .sqw_o(sqw), .pi_pulse_o(pulse), .sec_tick_o(sec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int unsigned period_of(input logic [3:0] r);
    if (r == 4'd1) return 128;
    if (r == 4'd2) return 256;
    return 32'd1 << (r - 1);
  endfunction

  function automatic logic sqw_model(input int unsigned c, input logic [3:0] r,
                                     input logic en, input logic [1:0] d);
    if (!en || r == 4'd0 || d != 2'b01) return 1'b0;
    return (c % period_of(r)) >= (period_of(r) / 2);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: model update at the rising edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    if (div_sel != 2'b01) begin
      mcnt = 0; pexp = 1'b0; sexp = 1'b0;
    end else if (tb_en) begin
      mcnt = (mcnt + 1) % 32768;
      pexp = pie_en && rate != 4'd0 && ((mcnt % period_of(rate)) == period_of(rate) / 2);
      sexp = (mcnt == 16384);
    end else begin
      pexp = 1'b0; sexp = 1'b0;
    end
    @(negedge clk);
    check("R3 sqw", sqw, sqw_model(mcnt, rate, sqw_en, div_sel));
    check("R4 periodic pulse", pulse, pexp);
    check("R6 second tick", sec, sexp);
  endtask

  task automatic count_window(input int n, output int np, output int ns);
    np = 0; ns = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pulse) np++;
      if (sec) ns++;
    end
  endtask

  task automatic restart();
    div_sel = 2'b00;
    step();
    div_sel = 2'b01;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int np;
    int ns;
    checks = 0; fails = 0; seed = 32'd4711;
    mcnt = 0; pexp = 0; sexp = 0;
    rst_n = 1'b0; tb_en = 1'b1; div_sel = 2'b01; rate = 4'd3;
    sqw_en = 1'b1; pie_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset sqw", sqw, 1'b0);
    check("R1 reset pulse", pulse, 1'b0);
    check("R1 reset sec", sec, 1'b0);
    tb_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 release sqw", sqw, 1'b0);
    check("R1 release pulse", pulse, 1'b0);

    // R2: rate code 6 gives 32 ticks, rate 1 gives 128, rate 2 gives 256
    tb_en = 1'b1; rate = 4'd6;
    restart();
    count_window(1024, np, ns);
    check_int("R2 rate6 pulses per 1024 ticks", np, 32);
    rate = 4'd1; restart();
    count_window(1024, np, ns);
    check_int("R2 rate1 pulses per 1024 ticks", np, 8);
    rate = 4'd2; restart();
    count_window(1024, np, ns);
    check_int("R2 rate2 pulses per 1024 ticks", np, 4);

    // R5: rate 0 silences both outputs
    rate = 4'd0; restart();
    count_window(300, np, ns);
    check_int("R5 rate0 pulses", np, 0);

    // R4: pie off blocks the pulse while sqw still toggles
    rate = 4'd3; pie_en = 1'b0; restart();
    count_window(64, np, ns);
    check_int("R4 pie off pulses", np, 0);
    pie_en = 1'b1;

    // R8: no counting without the time-base enable
    tb_en = 1'b0;
    count_window(100, np, ns);
    check_int("R8 idle pulses", np, 0);
    tb_en = 1'b1;

    // R7: stopped divider codes hold the chain cleared
    for (int d = 0; d < 4; d++) begin
      if (d == 1) continue;
      div_sel = 2'(d);
      count_window(20, np, ns);
      check_int("R7 stopped pulses", np, 0);
      check("R7 stopped sqw", sqw, 1'b0);
    end

    // R6: 1 Hz tick at 16384 then every 32768 ticks, any rate
    rate = 4'd15; pie_en = 1'b0; sqw_en = 1'b0; restart();
    count_window(49152, np, ns);
    check_int("R6 second ticks in 49152", ns, 2);

    // random mix
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      len = 10 + ($urandom(seed) % 90);
      seed = seed + 32'd1;
      rate    = 4'($urandom % 16);
      sqw_en  = 1'($urandom % 2);
      pie_en  = 1'($urandom % 2);
      div_sel = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'b01;
      for (int k = 0; k < len; k++) begin
        tb_en = (($urandom % 4) != 0);
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule